// File: doc/BRIEF.md
# Packed Interpolate and Merge Unit

This unit performs the per-pixel stepping work of a scan-line shader on one 64-bit word at a time. A command adds a packed delta operand to a packed running value, lane by lane, and returns the full-precision sums, so that the fractional bits carry forward into the next step. Alongside each step the unit keeps a 64-bit merge register. Depth steps collect the integer parts of the depth lanes into this register. Colour steps collect the top bits of each 16-bit lane into the pixel slot that belongs to that lane.

A 16-bit pixel is built in three colour passes, blue first, then green, then red. Each pass shifts the earlier fields down inside the slot and places the new field at the top. A final OR-merge command combines the collected word with a second operand, which can carry bits computed separately such as alpha. It returns the packed word and empties the merge register for the next group of pixels. Plain 64-bit add and subtract commands serve wide depth arithmetic and leave the merge register alone.

The interface accepts one command at a time through a valid/ready pair. It presents the result with a one-cycle valid pulse in the cycle after acceptance.

Top module: `imu_top`

## Requirements
- R1: After reset, res_valid_o and res_o are 0, cmd_ready_o is 1 and the merge register holds zero.
- R2: A command is accepted on a clock edge where cmd_valid_i and cmd_ready_o are both high. res_valid_o is high for exactly the following cycle, and cmd_ready_o is low while res_valid_o is high.
- R3: Op 0 (depth add, 16-bit depth) adds two 32-bit lanes with wraparound and no carry across bit 32. The merge register becomes {lane1 sum[31:16], lane0 sum[31:16], old merge[63:32]}.
- R4: Op 1 (depth add, 32-bit depth) returns the 64-bit sum opa_i + opb_i. The merge register becomes {sum[63:32], old merge[63:32]}.
- R5: Op 2 returns opa_i + opb_i and op 3 returns opa_i - opb_i, both modulo 2^64. Neither changes the merge register.
- R6: Op 4 (pixel add) returns four independent 16-bit wraparound sums, where lane i is bits [16i+15:16i].
- R7: On op 4 with field width N = cmd_width_i (values above 16 act as 16), every 16-bit merge slot i becomes (slot >> N) OR (lane i sum with its low 16-N bits cleared). N = 0 leaves the slot unchanged.
- R8: Three op-4 passes with widths 4, 6, 6 (blue, green, red) leave red in slot bits [15:10], green in [9:4] and blue in [3:0].
- R9: Op 5 (OR-merge) returns merge OR opa_i, ignores opb_i, and clears the merge register after it returns the result.
- R10: Ops 6 and 7 return 0 and leave the merge register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Unit can take a command |
| cmd_op_i | input | 3 | Command code (0..7, see requirements) |
| cmd_width_i | input | 5 | Colour field width for op 4 |
| opa_i | input | 64 | Running value, or OR operand for op 5 |
| opb_i | input | 64 | Packed delta, or subtrahend for op 3 |
| res_valid_o | output | 1 | Result valid pulse |
| res_o | output | 64 | Result word |

## Verification
Two functions share one cycle in this unit. Every add returns its sum and deposits into the merge register on the same edge. The OR-merge reads the register and clears it on the same edge. The bench interleaves sums with merge deposits, places plain adds and reserved codes between deposits, and issues back-to-back OR-merges. Each returned sum is compared against a reference model. The merge contents are judged only through later OR-merge results, including a second OR-merge that must return exactly its own operand.

// File: rtl/imu_pkg.sv
package imu_pkg;
  typedef enum logic [2:0] {
    OP_ZADD16 = 3'd0,
    OP_ZADD32 = 3'd1,
    OP_ADD64  = 3'd2,
    OP_SUB64  = 3'd3,
    OP_PADD   = 3'd4,
    OP_ORM    = 3'd5,
    OP_RSV6   = 3'd6,
    OP_RSV7   = 3'd7
  } imu_op_e;
endpackage

// File: rtl/imu_lane_add.sv
module imu_lane_add #(
  parameter int DW = 64,
  parameter int LW = 16
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          sub_i,
  output logic [DW-1:0] sum_o
);
  localparam int NL = DW / LW;

  for (genvar l = 0; l < NL; l++) begin : g_lane
    logic [LW-1:0] b_eff;
    assign b_eff = sub_i ? ~b_i[l*LW +: LW] : b_i[l*LW +: LW];
    // carry confined to the lane
    assign sum_o[l*LW +: LW] = a_i[l*LW +: LW] + b_eff + {{(LW-1){1'b0}}, sub_i};
  end
endmodule

// File: rtl/imu_merge.sv
module imu_merge
  import imu_pkg::*;
#(
  parameter int DW = 64,
  parameter int PW = 16,
  parameter int WW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  imu_op_e       op_i,
  input  logic [WW-1:0] width_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW/2-1:0] zint_i,
  input  logic [DW/2-1:0] zhi_i,
  input  logic [DW-1:0] pix_sum_i,
  output logic [DW-1:0] merge_o,
  output logic [DW-1:0] or_o
);
  localparam int NP = DW / PW;
  localparam int HW = DW / 2;

  logic [DW-1:0] merge_q, merge_d, pix_next;
  logic [WW-1:0] n_eff;

  assign n_eff = (width_i > WW'(PW)) ? WW'(PW) : width_i;

  for (genvar p = 0; p < NP; p++) begin : g_slot
    logic [PW-1:0] keep_mask;
    assign keep_mask = ~({PW{1'b1}} >> n_eff);
    assign pix_next[p*PW +: PW] = (merge_q[p*PW +: PW] >> n_eff)
                                | (pix_sum_i[p*PW +: PW] & keep_mask);
  end

  always_comb begin
    merge_d = merge_q;
    unique case (op_i)
      OP_ZADD16: merge_d = {zint_i, merge_q[DW-1:HW]};
      OP_ZADD32: merge_d = {zhi_i, merge_q[DW-1:HW]};
      OP_PADD:   merge_d = pix_next;
      OP_ORM:    merge_d = '0;
      default:   merge_d = merge_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   merge_q <= '0;
    else if (en_i) merge_q <= merge_d;
  end

  assign merge_o = merge_q;
  assign or_o    = merge_q | a_i;

  AST_ORM_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && op_i == OP_ORM |=> merge_q == '0); // R9
  AST_PLAIN_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && (op_i == OP_ADD64 || op_i == OP_SUB64 || op_i == OP_RSV6 || op_i == OP_RSV7)
    |=> $stable(merge_q)); // R5 R10
  AST_ZDEPOSIT_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && (op_i == OP_ZADD16 || op_i == OP_ZADD32)
    |=> merge_q[HW-1:0] == $past(merge_q[DW-1:HW])); // R3 R4
endmodule

// File: rtl/imu_top.sv
module imu_top
  import imu_pkg::*;
#(
  parameter int DW = 64,
  parameter int ZW = 32,
  parameter int PW = 16,
  parameter int WW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  output logic          cmd_ready_o,
  input  logic [2:0]    cmd_op_i,
  input  logic [WW-1:0] cmd_width_i,
  input  logic [DW-1:0] opa_i,
  input  logic [DW-1:0] opb_i,
  output logic          res_valid_o,
  output logic [DW-1:0] res_o
);
  localparam int NZ = DW / ZW;
  localparam int ZI = ZW / 2;
  localparam int HW = DW / 2;

  imu_op_e       op;
  logic          accept, res_valid_q;
  logic [DW-1:0] z16_sum, wide_sum, pix_sum, or_val, merge_val, res_d, res_q;
  logic [HW-1:0] zint;

  assign op          = imu_op_e'(cmd_op_i);
  assign cmd_ready_o = ~res_valid_q;
  assign accept      = cmd_valid_i & cmd_ready_o;

  imu_lane_add #(.DW(DW), .LW(ZW)) u_zadd (
    .a_i(opa_i), .b_i(opb_i), .sub_i(1'b0), .sum_o(z16_sum));
  imu_lane_add #(.DW(DW), .LW(DW)) u_wide (
    .a_i(opa_i), .b_i(opb_i), .sub_i(op == OP_SUB64), .sum_o(wide_sum));
  imu_lane_add #(.DW(DW), .LW(PW)) u_padd (
    .a_i(opa_i), .b_i(opb_i), .sub_i(1'b0), .sum_o(pix_sum));

  for (genvar k = 0; k < NZ; k++) begin : g_zint
    assign zint[k*ZI +: ZI] = z16_sum[k*ZW + ZI +: ZI];
  end

  imu_merge #(.DW(DW), .PW(PW), .WW(WW)) u_merge (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(accept), .op_i(op),
    .width_i(cmd_width_i), .a_i(opa_i), .zint_i(zint),
    .zhi_i(wide_sum[DW-1:HW]), .pix_sum_i(pix_sum),
    .merge_o(merge_val), .or_o(or_val));

  always_comb begin
    unique case (op)
      OP_ZADD16:                   res_d = z16_sum;
      OP_ZADD32, OP_ADD64, OP_SUB64: res_d = wide_sum;
      OP_PADD:                     res_d = pix_sum;
      OP_ORM:                      res_d = or_val;
      default:                     res_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_q <= 1'b0;
      res_q       <= '0;
    end else begin
      res_valid_q <= accept;
      if (accept) res_q <= res_d;
    end
  end

  assign res_valid_o = res_valid_q;
  assign res_o       = res_q;

  AST_RES_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> res_valid_o); // R2
  AST_RES_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o); // R2
  AST_Z16_HIGH_LANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && op == OP_ZADD16
    |=> res_o[DW-1:HW] == HW'($past(opa_i[DW-1:HW]) + $past(opb_i[DW-1:HW]))); // R3
  AST_ORM_RETURNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && op == OP_ORM |=> res_o == ($past(merge_val) | $past(opa_i))); // R9
endmodule

// File: tb/sim_imu_top.sv
module sim_imu_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic        cmd_ready_o;
  logic [2:0]  cmd_op_i = '0;
  logic [4:0]  cmd_width_i = '0;
  logic [63:0] opa_i = '0, opb_i = '0;
  logic        res_valid_o;
  logic [63:0] res_o;

  int n_chk = 0, n_fail = 0;
  logic [63:0] mdl_merge = '0;
  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  imu_top u0 (.*);

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] model(logic [2:0] op, logic [4:0] w,
                                        logic [63:0] a, logic [63:0] b);
    logic [63:0] r;
    r = '0;
    case (op)
      3'd0: begin
        logic [31:0] s0, s1;
        s0 = a[31:0] + b[31:0];
        s1 = a[63:32] + b[63:32];
        r = {s1, s0};
        mdl_merge = {s1[31:16], s0[31:16], mdl_merge[63:32]};
      end
      3'd1: begin
        r = a + b;
        mdl_merge = {r[63:32], mdl_merge[63:32]};
      end
      3'd2: r = a + b;
      3'd3: r = a - b;
      3'd4: begin
        int n;
        n = (w > 16) ? 16 : int'(w);
        for (int i = 0; i < 4; i++) begin
          logic [15:0] s, slot, m;
          s = a[16*i +: 16] + b[16*i +: 16];
          r[16*i +: 16] = s;
          m = ~(16'hFFFF >> n);
          slot = (mdl_merge[16*i +: 16] >> n) | (s & m);
          mdl_merge[16*i +: 16] = slot;
        end
      end
      3'd5: begin
        r = mdl_merge | a;
        mdl_merge = '0;
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic drive(string tag, logic [2:0] op, logic [4:0] w,
                       logic [63:0] a, logic [63:0] b);
    @(negedge clk_i);
    while (!cmd_ready_o) @(negedge clk_i);
    exp_q.push_back(model(op, w, a, b));
    tag_q.push_back(tag);
    cmd_op_i = op; cmd_width_i = w; opa_i = a; opb_i = b;
    cmd_valid_i = 1'b1;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    check({tag, " R2 ready low while valid"}, {63'd0, cmd_ready_o}, 64'd0);
    @(negedge clk_i);
    check({tag, " R2 valid single cycle"}, {63'd0, res_valid_o}, 64'd0);
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && res_valid_o) begin
      if (exp_q.size() == 0) check("R2 unexpected result", 64'd1, 64'd0);
      else check(tag_q.pop_front(), res_o, exp_q.pop_front());
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3);
    check("R1 res_valid reset", {63'd0, res_valid_o}, 64'd0);
    check("R1 ready reset", {63'd0, cmd_ready_o}, 64'd1);
    check("R1 result reset", res_o, 64'd0);
    @(negedge clk_i) rst_ni = 1'b1;
    drive("R1 merge empty", 3'd5, 5'd0, 64'd0, 64'hFFFF);

    drive("R3 low lane carry blocked", 3'd0, 0, 64'h0000_0001_FFFF_FFFF, 64'h0000_0000_0000_0001);
    drive("R3 high lane wraps", 3'd0, 0, 64'hFFFF_8000_1234_0000, 64'h0001_8000_0001_0000);
    drive("R3 depth merge", 3'd5, 0, 64'd0, 64'd0);

    drive("R4 wide depth a", 3'd1, 0, 64'h0000_00FF_FFFF_FFFF, 64'h0000_0000_0000_0001);
    drive("R5 add between deposits", 3'd2, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2);
    drive("R5 sub wraps", 3'd3, 0, 64'd0, 64'd1);
    drive("R4 wide depth b", 3'd1, 0, 64'hABCD_0000_0000_0000, 64'h0000_1234_0000_0000);
    drive("R4 R5 depth merge", 3'd5, 0, 64'd0, 64'd0);

    drive("R6 lanes wrap", 3'd4, 5'd16, 64'hFFFF_8000_0001_7FFF, 64'h0001_8000_FFFF_0001);
    drive("R7 width zero keeps", 3'd4, 5'd0, 64'h1111_2222_3333_4444, 64'h0);
    drive("R7 width over 16 clamps", 3'd4, 5'd20, 64'h0F0F_F0F0_00FF_FF00, 64'h0001_0001_0001_0001);
    drive("R7 pixel merge", 3'd5, 0, 64'd0, 64'd0);

    drive("R8 blue pass", 3'd4, 5'd4, 64'hE000_E000_E000_E000, 64'h1000_1000_1000_1000);
    drive("R8 green pass", 3'd4, 5'd6, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000);
    drive("R8 red pass", 3'd4, 5'd6, 64'hFC00_FC00_FC00_FC00, 64'h0000_0000_0000_0000);
    // expected packed word FC0F per slot, OR with alpha-like bits; opb ignored
    drive("R8 R9 packed pixels", 3'd5, 0, 64'h0000_0000_0000_0030, 64'hFFFF_FFFF_FFFF_FFFF);
    drive("R9 merge cleared", 3'd5, 0, 64'h0000_0000_0000_5A5A, 64'h1234);

    drive("R10 deposit before reserved", 3'd0, 0, 64'h7000_0000_0300_0000, 64'h0);
    drive("R10 reserved six", 3'd6, 0, 64'hFFFF, 64'hFFFF);
    drive("R10 reserved seven", 3'd7, 0, 64'hFFFF, 64'hFFFF);
    drive("R10 merge untouched", 3'd5, 0, 64'd0, 64'd0);

    repeat (3) @(negedge clk_i);
    check("R2 all results seen", 64'(exp_q.size()), 64'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule